// File: doc/BRIEF.md
# Serial Field Memory Write Controller

This block runs the write side of one serial field-memory channel. On every write-clock edge it samples a pointer-clear input, a write-enable input, a write-mask input and an 8-bit data word. It keeps a wrapping write pointer and turns these controls into a one-word write request, an address and data for an on-chip memory array. The array itself and the read side are not part of the block.

Write-enable gates whether the pointer moves. The mask only gates whether the addressed word is stored, so a masked cycle still steps past its location. This lets a picture be overlaid into selected parts of a stored field. Two static configuration inputs change how the controls are taken. One inverts the active level of all three controls. The other adds a one-cycle stage in front of the pointer logic, so that the write path lags the read path by one clock and devices can be chained. The block also watches how the clear input is used. It raises sticky flags when the clear is re-asserted too soon after its release, or when a write run between two clears holds too few stored words.

Top module: `fmem_wr_ctrl`

## Requirements
- R1: In a cycle where the (decoded) clear control is active, no array write is issued whatever the enable and mask say, and the pointer becomes zero, so the next write lands at address 0.
- R2: With write-enable inactive and clear inactive, no array write is issued and `mem_addr_o` holds its value, whatever the mask input is.
- R3: With write-enable active and mask inactive, no array write is issued but `mem_addr_o` increments by one for the next cycle.
- R4: With write-enable and mask both active, `mem_we_o` is 1, `mem_addr_o` is the current pointer and `mem_data_o` the sampled data word; the pointer then increments.
- R5: With `cfg_invert` = 0 the controls `ptr_clr_i`, `wen_i` and `mask_en_i` are active at 1; with `cfg_invert` = 1 they are active at 0.
- R6: With `cfg_cascade` = 0 the write request, address and data appear in the same cycle as the sampled controls; with `cfg_cascade` = 1 they appear one cycle later, carrying the data word of the earlier cycle.
- R7: A new assertion of clear after fewer than 2 deasserted cycles since the previous assertion sets `spacing_err_o`; a gap of 2 or more cycles does not.
- R8: A new assertion of clear after fewer than 80 stored words since the previous clear sets `short_run_err_o`; 80 or more does not, and the first clear after a global reset never does.
- R9: The pointer wraps from DEPTH-1 to 0.
- R10: Both flags are sticky until the synchronous active-low `rst_n`, which clears both flags and the pointer and empties the cascade stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst_n | input | 1 | Synchronous global reset, active low |
| cfg_invert | input | 1 | Static: 1 makes the controls active low |
| cfg_cascade | input | 1 | Static: 1 delays the access by one cycle |
| ptr_clr_i | input | 1 | Write pointer clear control |
| wen_i | input | 1 | Write enable, gates the pointer advance |
| mask_en_i | input | 1 | Write mask enable, gates the array store |
| din_i | input | 8 | Write data word |
| mem_we_o | output | 1 | Array write request |
| mem_addr_o | output | log2(DEPTH) | Array write address (current pointer) |
| mem_data_o | output | 8 | Array write data |
| spacing_err_o | output | 1 | Sticky flag: clear re-asserted too soon |
| short_run_err_o | output | 1 | Sticky flag: too few stored words between clears |

## Verification
A pointer that drifts shows at once on `mem_addr_o`, because the address port is the pointer. One missed or extra advance therefore moves every later write address, starting with the next cycle. A wrong enable or mask decode shows as a `mem_we_o` pulse that is missing or extra in that same cycle, or one cycle later in cascade mode. Faults in the gap or run counters stay hidden until the next clear assertion. At that point a flag either fails to rise or rises wrongly in the following cycle, so the bench places clears exactly at the 1-versus-2 gap boundary and the 79-versus-80 run boundary.

// File: rtl/fmem_wr_pkg.sv
package fmem_wr_pkg;

  typedef struct packed {
    logic clr;
    logic wen;
    logic ien;
  } fmem_ctl_t;

  // raw pin level to active flag, given the polarity setting
  function automatic logic fmem_level(input logic raw, input logic inv);
    return raw ^ inv;
  endfunction

  function automatic fmem_ctl_t fmem_decode(input logic clr, input logic wen,
                                            input logic ien, input logic inv);
    fmem_ctl_t c;
    c.clr = fmem_level(clr, inv);
    c.wen = fmem_level(wen, inv);
    c.ien = fmem_level(ien, inv);
    return c;
  endfunction

  // a word is stored into the array
  function automatic logic fmem_fire(input fmem_ctl_t c);
    return c.wen & c.ien & ~c.clr;
  endfunction

  // the pointer moves on
  function automatic logic fmem_adv(input fmem_ctl_t c);
    return c.wen & ~c.clr;
  endfunction

endpackage

// File: rtl/fmem_ctl_stage.sv
module fmem_ctl_stage
  import fmem_wr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cascade_i,
  input  fmem_ctl_t       ctl_i,
  input  logic [DW-1:0]   din_i,
  output fmem_ctl_t       ctl_o,
  output logic [DW-1:0]   dout_o
);

  fmem_ctl_t     ctl_q;
  logic [DW-1:0] din_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
      din_q <= '0;
    end else begin
      ctl_q <= ctl_i;
      din_q <= din_i;
    end
  end

  always_comb begin
    if (cascade_i) begin
      ctl_o  = ctl_q;
      dout_o = din_q;
    end else begin
      ctl_o  = ctl_i;
      dout_o = din_i;
    end
  end

endmodule

// File: rtl/fmem_wr_ptr.sv
module fmem_wr_ptr
  import fmem_wr_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  fmem_ctl_t     ctl_i,
  output logic [AW-1:0] ptr_o
);

  logic [AW-1:0] ptr_q;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p,
                                             input fmem_ctl_t c);
    if (c.clr)
      return '0;
    else if (fmem_adv(c))
      return p + AW'(1);
    else
      return p;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)
      ptr_q <= '0;
    else
      ptr_q <= ptr_next(ptr_q, ctl_i);
  end

  assign ptr_o = ptr_q;

endmodule

// File: rtl/fmem_rule_mon.sv
module fmem_rule_mon
  import fmem_wr_pkg::*;
#(
  parameter int MIN_GAP = 2,
  parameter int MIN_RUN = 80
) (
  input  logic      clk,
  input  logic      rst_n,
  input  fmem_ctl_t ctl_i,
  output logic      clr_rise_o,
  output logic      spacing_err_o,
  output logic      short_err_o
);

  localparam int GW = $clog2(MIN_GAP + 1);
  localparam int RW = $clog2(MIN_RUN + 1);

  logic          clr_q;
  logic          seen_q;
  logic [GW-1:0] gap_q;
  logic [RW-1:0] run_q;
  logic          spc_q;
  logic          sht_q;
  logic          gap_short;
  logic          run_short;

  assign clr_rise_o = ctl_i.clr & ~clr_q;
  assign gap_short  = seen_q && (gap_q < GW'(MIN_GAP));
  assign run_short  = seen_q && (run_q < RW'(MIN_RUN));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clr_q  <= 1'b0;
      seen_q <= 1'b0;
      gap_q  <= '0;
      run_q  <= '0;
      spc_q  <= 1'b0;
      sht_q  <= 1'b0;
    end else begin
      clr_q <= ctl_i.clr;
      if (ctl_i.clr) begin
        gap_q  <= '0;
        run_q  <= '0;
        seen_q <= 1'b1;
      end else begin
        if (gap_q != GW'(MIN_GAP))
          gap_q <= gap_q + GW'(1);
        if (fmem_fire(ctl_i) && (run_q != RW'(MIN_RUN)))
          run_q <= run_q + RW'(1);
      end
      if (clr_rise_o && gap_short)
        spc_q <= 1'b1;
      if (clr_rise_o && run_short)
        sht_q <= 1'b1;
    end
  end

  assign spacing_err_o = spc_q;
  assign short_err_o   = sht_q;

endmodule

// File: rtl/fmem_wr_ctrl.sv
module fmem_wr_ctrl
  import fmem_wr_pkg::*;
#(
  parameter int DEPTH   = 1024,
  parameter int DW      = 8,
  parameter int MIN_GAP = 2,
  parameter int MIN_RUN = 80,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_invert,
  input  logic          cfg_cascade,
  input  logic          ptr_clr_i,
  input  logic          wen_i,
  input  logic          mask_en_i,
  input  logic [DW-1:0] din_i,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_data_o,
  output logic          spacing_err_o,
  output logic          short_run_err_o
);

  fmem_ctl_t     in_ctl;
  fmem_ctl_t     st_ctl;
  logic [DW-1:0] st_din;
  logic [AW-1:0] ptr;

  // named events for the checker
  logic in_clr;
  logic in_fire;
  logic st_clr;
  logic st_wen;
  logic clr_rise;

  assign in_ctl  = fmem_decode(ptr_clr_i, wen_i, mask_en_i, cfg_invert);
  assign in_clr  = in_ctl.clr;
  assign in_fire = fmem_fire(in_ctl);

  fmem_ctl_stage #(.DW(DW)) stage_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cascade_i (cfg_cascade),
    .ctl_i     (in_ctl),
    .din_i     (din_i),
    .ctl_o     (st_ctl),
    .dout_o    (st_din)
  );

  assign st_clr = st_ctl.clr;
  assign st_wen = st_ctl.wen;

  fmem_wr_ptr #(.AW(AW)) ptr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .ctl_i (st_ctl),
    .ptr_o (ptr)
  );

  fmem_rule_mon #(.MIN_GAP(MIN_GAP), .MIN_RUN(MIN_RUN)) mon_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctl_i         (st_ctl),
    .clr_rise_o    (clr_rise),
    .spacing_err_o (spacing_err_o),
    .short_err_o   (short_run_err_o)
  );

  assign mem_we_o   = fmem_fire(st_ctl);
  assign mem_addr_o = ptr;
  assign mem_data_o = st_din;

endmodule

// File: rtl/fmem_wr_chk.sv
module fmem_wr_chk #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_cascade,
  input logic          in_clr,
  input logic          in_fire,
  input logic          st_clr,
  input logic          st_wen,
  input logic          clr_rise,
  input logic [DW-1:0] din_i,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_data_o,
  input logic          spacing_err_o,
  input logic          short_run_err_o
);

  // R1
  clr_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_cascade && in_clr) |-> !mem_we_o);

  // R1
  clr_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_clr |=> (mem_addr_o == '0));

  // R2
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_clr && !st_wen) |=> $stable(mem_addr_o));

  // R3
  step_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_clr && st_wen) |=> (mem_addr_o == $past(mem_addr_o) + AW'(1)));

  // R6
  cascade_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_cascade && $past(cfg_cascade) && in_fire) |=> mem_we_o);

  // R6
  cascade_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_cascade && in_fire) |=> (mem_data_o == $past(din_i)));

  // R7
  spacing_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spacing_err_o |=> spacing_err_o);

  // R8
  short_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    short_run_err_o |=> short_run_err_o);

  // R7
  spacing_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spacing_err_o) |-> $past(clr_rise));

endmodule

bind fmem_wr_ctrl fmem_wr_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .cfg_cascade     (cfg_cascade),
  .in_clr          (in_clr),
  .in_fire         (in_fire),
  .st_clr          (st_clr),
  .st_wen          (st_wen),
  .clr_rise        (clr_rise),
  .din_i           (din_i),
  .mem_we_o        (mem_we_o),
  .mem_addr_o      (mem_addr_o),
  .mem_data_o      (mem_data_o),
  .spacing_err_o   (spacing_err_o),
  .short_run_err_o (short_run_err_o)
);

// File: tb/fmem_wr_ctrl_tb.sv
module fmem_wr_ctrl_tb_top;

  localparam int DEPTH = 1024;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_invert = 1'b0;
  logic          cfg_cascade = 1'b0;
  logic          ptr_clr_i = 1'b0;
  logic          wen_i = 1'b0;
  logic          mask_en_i = 1'b0;
  logic [7:0]    din_i = '0;
  logic          mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [7:0]    mem_data_o;
  logic          spacing_err_o;
  logic          short_run_err_o;

  int checks = 0;
  int failures = 0;
  bit inv = 1'b0;

  always #10 clk = ~clk;

  fmem_wr_ctrl #(.DEPTH(DEPTH)) dut_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_invert      (cfg_invert),
    .cfg_cascade     (cfg_cascade),
    .ptr_clr_i       (ptr_clr_i),
    .wen_i           (wen_i),
    .mask_en_i       (mask_en_i),
    .din_i           (din_i),
    .mem_we_o        (mem_we_o),
    .mem_addr_o      (mem_addr_o),
    .mem_data_o      (mem_data_o),
    .spacing_err_o   (spacing_err_o),
    .short_run_err_o (short_run_err_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // drive one cycle with logical levels; sample point is 5 ns later
  task automatic drive(input bit clr, input bit wen, input bit ien,
                       input logic [7:0] d);
    @(negedge clk);
    ptr_clr_i = clr ^ inv;
    wen_i     = wen ^ inv;
    mask_en_i = ien ^ inv;
    din_i     = d;
    #5;
  endtask

  task automatic global_reset(input bit invert, input bit cascade);
    @(negedge clk);
    rst_n       = 1'b0;
    inv         = invert;
    cfg_invert  = invert;
    cfg_cascade = cascade;
    ptr_clr_i   = inv;
    wen_i       = inv;
    mask_en_i   = inv;
    din_i       = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state();
    global_reset(1'b0, 1'b0);
    drive(0, 0, 0, 8'h00);
    check("R10 addr after reset", mem_addr_o, 0);
    check("R10 we after reset", mem_we_o, 0);
    check("R10 flags after reset", {spacing_err_o, short_run_err_o}, 0);
  endtask

  task automatic t_basic_write();
    global_reset(1'b0, 1'b0);
    drive(1, 1, 1, 8'hEE);
    check("R1 no write in clear cycle", mem_we_o, 0);
    for (int i = 0; i < 3; i++) begin
      drive(0, 1, 1, 8'h30 + 8'(i));
      check("R4 we", mem_we_o, 1);
      check("R4 addr", mem_addr_o, i);
      check("R4 data", mem_data_o, 8'h30 + i);
    end
    drive(0, 1, 0, 8'h77);
    check("R3 masked no write", mem_we_o, 0);
    check("R3 masked addr", mem_addr_o, 3);
    drive(0, 0, 1, 8'h78);
    check("R3 addr stepped", mem_addr_o, 4);
    check("R2 no write when disabled", mem_we_o, 0);
    drive(0, 0, 0, 8'h79);
    check("R2 addr held", mem_addr_o, 4);
    drive(1, 1, 1, 8'h11);
    check("R1 clear ignores enables", mem_we_o, 0);
    drive(0, 1, 1, 8'h22);
    check("R1 write at zero after clear", mem_addr_o, 0);
    check("R1 write issued after clear", mem_we_o, 1);
  endtask

  task automatic t_active_low();
    global_reset(1'b1, 1'b0);
    drive(0, 0, 0, 8'h00);
    check("R5 idle raw-high no write", mem_we_o, 0);
    drive(1, 0, 0, 8'h00);
    drive(0, 1, 1, 8'h5C);
    check("R5 active-low write", mem_we_o, 1);
    check("R5 active-low data", mem_data_o, 8'h5C);
    drive(0, 1, 0, 8'h5D);
    check("R5 active-low mask", mem_we_o, 0);
    drive(0, 0, 0, 8'h00);
    check("R5 active-low addr", mem_addr_o, 2);
  endtask

  task automatic t_cascade();
    global_reset(1'b0, 1'b1);
    drive(1, 0, 0, 8'h00);
    drive(0, 1, 1, 8'hA1);
    check("R6 cascade no write yet", mem_we_o, 0);
    drive(0, 0, 0, 8'h00);
    check("R6 cascade delayed we", mem_we_o, 1);
    check("R6 cascade addr", mem_addr_o, 0);
    check("R6 cascade data", mem_data_o, 8'hA1);
    drive(0, 0, 0, 8'h00);
    check("R6 cascade after write", mem_we_o, 0);
    check("R6 cascade addr step", mem_addr_o, 1);
  endtask

  task automatic t_spacing();
    global_reset(1'b0, 1'b0);
    drive(1, 0, 0, 8'h00);
    drive(0, 0, 0, 8'h00);
    drive(0, 0, 0, 8'h00);
    drive(1, 0, 0, 8'h00);
    drive(0, 0, 0, 8'h00);
    check("R7 gap of two accepted", spacing_err_o, 0);
    drive(1, 0, 0, 8'h00);
    drive(0, 0, 0, 8'h00);
    check("R7 gap of one flagged", spacing_err_o, 1);
    repeat (5) drive(0, 0, 0, 8'h00);
    check("R10 spacing flag sticky", spacing_err_o, 1);
    global_reset(1'b0, 1'b0);
    drive(0, 0, 0, 8'h00);
    check("R10 flag cleared by rst_n", spacing_err_o, 0);
  endtask

  task automatic t_short_run();
    global_reset(1'b0, 1'b0);
    drive(1, 0, 0, 8'h00);
    drive(0, 0, 0, 8'h00);
    check("R8 first clear not flagged", short_run_err_o, 0);
    for (int i = 0; i < 80; i++) drive(0, 1, 1, 8'(i));
    drive(1, 0, 0, 8'h00);
    drive(0, 0, 0, 8'h00);
    check("R8 run of 80 accepted", short_run_err_o, 0);
    for (int i = 0; i < 79; i++) drive(0, 1, 1, 8'(i));
    drive(0, 1, 0, 8'h00);
    drive(1, 0, 0, 8'h00);
    drive(0, 0, 0, 8'h00);
    check("R8 run of 79 flagged", short_run_err_o, 1);
  endtask

  task automatic t_wrap();
    global_reset(1'b0, 1'b0);
    drive(1, 0, 0, 8'h00);
    for (int i = 0; i < DEPTH; i++) begin
      drive(0, 1, 0, 8'h00);
      if (i == DEPTH - 1)
        check("R9 last address", mem_addr_o, DEPTH - 1);
    end
    drive(0, 1, 1, 8'h99);
    check("R9 wrapped to zero", mem_addr_o, 0);
    check("R9 write after wrap", mem_we_o, 1);
  endtask

  initial begin
    t_reset_state();
    t_basic_write();
    t_active_low();
    t_cascade();
    t_spacing();
    t_short_run();
    t_wrap();
    summary();
    $finish;
  end

  initial begin
    #4000000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

endmodule